// File: doc/BRIEF.md
# LCD Segment Column Loader

This block is the digital core of an 80-column LCD segment driver. A display controller feeds it one row of pixel data through a shift strobe. In nibble mode it takes four data bits per strobe, so a row needs 20 strobes. In serial mode it takes one bit per strobe on data bit 0, so a row needs 80 strobes. A direction input reverses the order in which columns fill. When the latch clock falls, the row held in the shift register is copied into an output latch. Each column then drives a 2-bit level code, chosen from its latched bit, the AC phase input and an active-low blanking input.

Several loaders sit in a chain and share one data bus. An active-low enable token picks the loader that accepts data. A loader takes strobes only while its incoming enable is low. Once its row is complete, it drives its outgoing enable low, which hands the token to the next loader, and it ignores further strobes. A high level on the latch clock returns every outgoing enable high and clears the count, ready for the next row. The direction input decides which enable pin is the input and which is the output.

All inputs are sampled on `clk`. `shift_stb` is a one-cycle strobe. `lat_clk` is sampled as a level, and its falling edge is detected internally.

Top module: `lcd_seg_loader`

## Requirements
- R1: Synchronous reset clears the shift register, the output latch and the count, and sets the outgoing enable high. After reset, with `blank_n`=1 and `ac_phase`=0, every column shows code 01.
- R2: With `load_sel`=0 and `dir_rev`=0, each accepted strobe takes `din[3:0]`. Once the row is complete and latched, nibble number k (counting from 0) lies at columns 4k..4k+3, with `din[j]` at column 4k+j. Column c drives `lvl_code[2c+1:2c]`.
- R3: With `load_sel`=1 and `dir_rev`=0, each accepted strobe takes only `din[0]`, and accepted bit k ends at column k. `din[3:1]` have no effect.
- R4: With `dir_rev`=1, the placement is mirrored. Serial bit k ends at column 79-k. In nibble mode, `din[j]` of nibble k ends at column 79-(4k+j).
- R5: The latch copies the shift register only on a high-to-low transition of `lat_clk`. At all other times the level codes do not change while a new row is being shifted.
- R6: A strobe is ignored while the incoming enable is high. The incoming enable is `en_right_i` when `dir_rev`=0 and `en_left_i` when `dir_rev`=1.
- R7: After 20 accepted strobes in nibble mode, or 80 in serial mode, the outgoing enable goes low. Further strobes are then ignored until `lat_clk` goes high.
- R8: While `lat_clk` is high, the outgoing enable goes high, the count clears and strobes are ignored.
- R9: With `dir_rev`=0, the left enable pin is the driven output (`en_left_oe`=1, `en_right_oe`=0). With `dir_rev`=1, the roles swap. Both output values carry the outgoing enable.
- R10: Level codes: 00=V0, 01=low non-select, 10=high non-select, 11=V5. With `ac_phase`=0, a latched 1 gives 11 and a latched 0 gives 01. With `ac_phase`=1, a latched 1 gives 00 and a latched 0 gives 10.
- R11: While `blank_n` is low, every column shows 00, whatever the latched data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_stb | input | 1 | One-cycle shift strobe |
| lat_clk | input | 1 | Row latch clock, sampled as a level |
| load_sel | input | 1 | 0 = nibble loading, 1 = serial loading |
| dir_rev | input | 1 | 0 = left-to-right fill, 1 = reversed fill |
| din | input | 4 | Pixel data bus |
| ac_phase | input | 1 | AC inversion phase |
| blank_n | input | 1 | Active-low display blanking |
| en_left_i | input | 1 | Left enable pin, input value |
| en_left_o | output | 1 | Left enable pin, output value |
| en_left_oe | output | 1 | Left enable pin, output enable |
| en_right_i | input | 1 | Right enable pin, input value |
| en_right_o | output | 1 | Right enable pin, output value |
| en_right_oe | output | 1 | Right enable pin, output enable |
| lvl_code | output | 160 | Two-bit level code per column |

## Verification
The loader is driven with rows in nibble and serial mode, in both fill directions, using distinct per-unit bit patterns, so a swapped nibble, a flipped bit order or a wrong mirror shows up as a misplaced column. Surplus strobes are sent after a row completes, while the token is withheld, and while the latch clock is high. These tell apart a loader that counts or gates correctly from one that overwrites data or hands the token on early. The AC phase and blanking inputs are then swept over the latched rows to separate the four level codes.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

    typedef enum logic [1:0] {
        LVL_V0    = 2'b00,
        LVL_NS_LO = 2'b01,
        LVL_NS_HI = 2'b10,
        LVL_V5    = 2'b11
    } lvl_e;

    function automatic lvl_e pick_level(input logic pix, input logic ac, input logic blank_n);
        lvl_e r;
        if (!blank_n)
            r = LVL_V0;
        else if (pix)
            r = ac ? LVL_V0 : LVL_V5;
        else
            r = ac ? LVL_NS_HI : LVL_NS_LO;
        return r;
    endfunction

endpackage

// File: rtl/lcd_shift_core.sv
module lcd_shift_core #(
    parameter int NCOL  = 80,
    parameter int PAR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_stb,
    input  logic             lat_clk,
    input  logic             load_sel,
    input  logic             dir_rev,
    input  logic [PAR_W-1:0] din,
    input  logic             en_in,
    output logic [NCOL-1:0]  sr_row,
    output logic             en_out
);
    localparam int NGRP = NCOL / PAR_W;
    localparam int CW   = $clog2(NCOL + 1);
    localparam logic [CW-1:0] TGT_SER = CW'(NCOL);
    localparam logic [CW-1:0] TGT_PAR = CW'(NGRP);

    typedef struct packed {
        logic [NCOL-1:0] sr;
        logic [CW-1:0]   cnt;
        logic            eo;
    } core_st_t;

    core_st_t s_d, s_q;
    logic [PAR_W-1:0] din_rev;
    logic [CW-1:0]    tgt;
    logic [CW-1:0]    cnt_inc;
    logic             take;

    always_comb begin
        for (int j = 0; j < PAR_W; j++) begin
            din_rev[j] = din[PAR_W-1-j];
        end
        tgt     = load_sel ? TGT_SER : TGT_PAR;
        cnt_inc = s_q.cnt + 1'b1;
        take    = shift_stb && !en_in && s_q.eo && !lat_clk;
        s_d     = s_q;
        if (lat_clk) begin
            s_d.cnt = '0;
            s_d.eo  = 1'b1;
        end else if (take) begin
            if (load_sel) begin
                if (dir_rev) s_d.sr = {s_q.sr[NCOL-2:0], din[0]};
                else         s_d.sr = {din[0], s_q.sr[NCOL-1:1]};
            end else begin
                if (dir_rev) s_d.sr = {s_q.sr[NCOL-PAR_W-1:0], din_rev};
                else         s_d.sr = {din, s_q.sr[NCOL-1:PAR_W]};
            end
            s_d.cnt = cnt_inc;
            if (cnt_inc == tgt) s_d.eo = 1'b0;
        end
        if (rst) begin
            s_d.sr  = '0;
            s_d.cnt = '0;
            s_d.eo  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign sr_row = s_q.sr;
    assign en_out = s_q.eo;

endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch #(
    parameter int NCOL = 80
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lat_clk,
    input  logic [NCOL-1:0] sr_row,
    output logic [NCOL-1:0] lat_row
);
    typedef struct packed {
        logic [NCOL-1:0] row;
        logic            prev;
    } lat_st_t;

    lat_st_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.prev = lat_clk;
        if (l_q.prev && !lat_clk) l_d.row = sr_row;
        if (rst) begin
            l_d.row  = '0;
            l_d.prev = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        l_q <= l_d;
    end

    assign lat_row = l_q.row;

endmodule

// File: rtl/lcd_level_sel.sv
module lcd_level_sel
    import lcd_seg_pkg::*;
#(
    parameter int NCOL = 80
) (
    input  logic [NCOL-1:0]   lat_row,
    input  logic              ac_phase,
    input  logic              blank_n,
    output logic [2*NCOL-1:0] lvl_code
);
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        assign lvl_code[2*c+1:2*c] = pick_level(lat_row[c], ac_phase, blank_n);
    end

endmodule

// File: rtl/lcd_seg_loader.sv
module lcd_seg_loader #(
    parameter int NCOL  = 80,
    parameter int PAR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_stb,
    input  logic              lat_clk,
    input  logic              load_sel,
    input  logic              dir_rev,
    input  logic [PAR_W-1:0]  din,
    input  logic              ac_phase,
    input  logic              blank_n,
    input  logic              en_left_i,
    output logic              en_left_o,
    output logic              en_left_oe,
    input  logic              en_right_i,
    output logic              en_right_o,
    output logic              en_right_oe,
    output logic [2*NCOL-1:0] lvl_code
);
    logic [NCOL-1:0] sr_row;
    logic [NCOL-1:0] lat_row;
    logic            en_in;
    logic            en_out;

    assign en_in = dir_rev ? en_left_i : en_right_i;

    lcd_shift_core #(.NCOL(NCOL), .PAR_W(PAR_W)) u_core (
        .clk(clk), .rst(rst), .shift_stb(shift_stb), .lat_clk(lat_clk),
        .load_sel(load_sel), .dir_rev(dir_rev), .din(din), .en_in(en_in),
        .sr_row(sr_row), .en_out(en_out)
    );

    lcd_row_latch #(.NCOL(NCOL)) u_latch (
        .clk(clk), .rst(rst), .lat_clk(lat_clk), .sr_row(sr_row), .lat_row(lat_row)
    );

    lcd_level_sel #(.NCOL(NCOL)) u_lvl (
        .lat_row(lat_row), .ac_phase(ac_phase), .blank_n(blank_n), .lvl_code(lvl_code)
    );

    assign en_left_o   = en_out;
    assign en_right_o  = en_out;
    assign en_left_oe  = !dir_rev;
    assign en_right_oe = dir_rev;

endmodule

// File: rtl/lcd_seg_loader_chk.sv
module lcd_seg_loader_chk #(
    parameter int NCOL = 80
) (
    input logic              clk,
    input logic              rst,
    input logic              shift_stb,
    input logic              lat_clk,
    input logic              dir_rev,
    input logic              en_left_i,
    input logic              en_right_i,
    input logic              en_left_o,
    input logic              en_left_oe,
    input logic              en_right_oe,
    input logic              blank_n,
    input logic [2*NCOL-1:0] lvl_code,
    input logic [NCOL-1:0]   sr_row,
    input logic [NCOL-1:0]   lat_row
);
    // R9
    pin_role_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({en_left_oe, en_right_oe}) && (en_right_oe == dir_rev));

    // R6
    gated_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_stb && (dir_rev ? en_left_i : en_right_i)) |=> $stable(sr_row));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_left_o && !lat_clk) |=> $stable(sr_row));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        lat_clk |=> $stable(lat_row));

    // R8
    token_restore_chk: assert property (@(posedge clk) disable iff (rst)
        lat_clk |=> en_left_o);

    // R11
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        !blank_n |-> (lvl_code == '0));

endmodule

bind lcd_seg_loader lcd_seg_loader_chk #(.NCOL(NCOL)) u_chk (
    .clk(clk), .rst(rst), .shift_stb(shift_stb), .lat_clk(lat_clk),
    .dir_rev(dir_rev), .en_left_i(en_left_i), .en_right_i(en_right_i),
    .en_left_o(en_left_o), .en_left_oe(en_left_oe), .en_right_oe(en_right_oe),
    .blank_n(blank_n), .lvl_code(lvl_code), .sr_row(sr_row), .lat_row(lat_row)
);

// File: tb/tb_lcd_seg_loader.sv
module tb_lcd_seg_loader;
    localparam int NC = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_stb = 1'b0, lat_clk = 1'b0, load_sel = 1'b0, dir_rev = 1'b0;
    logic [3:0] din = 4'h0;
    logic ac_phase = 1'b0, blank_n = 1'b1;
    logic en_left_i = 1'b1, en_right_i = 1'b0;
    logic en_left_o, en_left_oe, en_right_o, en_right_oe;
    logic [2*NC-1:0] lvl_code;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string phase = "R1";

    // behavioural model
    bit mq[$];
    bit mlat[NC];
    int mcnt;
    bit meo;
    bit mprev;

    always #10 clk = ~clk;

    lcd_seg_loader dut (
        .clk(clk), .rst(rst), .shift_stb(shift_stb), .lat_clk(lat_clk),
        .load_sel(load_sel), .dir_rev(dir_rev), .din(din), .ac_phase(ac_phase),
        .blank_n(blank_n), .en_left_i(en_left_i), .en_left_o(en_left_o),
        .en_left_oe(en_left_oe), .en_right_i(en_right_i), .en_right_o(en_right_o),
        .en_right_oe(en_right_oe), .lvl_code(lvl_code)
    );

    function automatic logic [1:0] exp_code(bit pix);
        case ({blank_n, ac_phase, pix})
            3'b100:  return 2'b01;
            3'b101:  return 2'b11;
            3'b110:  return 2'b10;
            3'b111:  return 2'b00;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit en_in;
        bit tmp;
        if (rst) begin
            mq.delete();
            for (int i = 0; i < NC; i++) mq.push_back(1'b0);
            foreach (mlat[i]) mlat[i] = 1'b0;
            mcnt = 0; meo = 1'b1; mprev = 1'b0;
            return;
        end
        if (mprev && !lat_clk) foreach (mlat[i]) mlat[i] = mq[i];
        en_in = dir_rev ? en_left_i : en_right_i;
        if (lat_clk) begin
            mcnt = 0; meo = 1'b1;
        end else if (shift_stb && !en_in && meo) begin
            for (int u = 0; u < (load_sel ? 1 : 4); u++) begin
                if (dir_rev) begin mq.push_front(din[u]); tmp = mq.pop_back(); end
                else         begin mq.push_back(din[u]);  tmp = mq.pop_front(); end
            end
            mcnt++;
            if (mcnt == (load_sel ? 80 : 20)) meo = 1'b0;
        end
        mprev = lat_clk;
    endtask

    task automatic compare_all();
        int first_bad;
        first_bad = -1;
        for (int c = NC - 1; c >= 0; c--)
            if (lvl_code[2*c+:2] !== exp_code(mlat[c])) first_bad = c;
        total++;
        if (first_bad >= 0) begin
            bad++;
            $display("FAIL %s: column %0d actual=%0d expected=%0d", phase, first_bad,
                     lvl_code[2*first_bad+:2], exp_code(mlat[first_bad]));
        end
        check({phase, " R9 enable pins"},
              {en_left_o, en_right_o, en_left_oe, en_right_oe},
              {meo, meo, !dir_rev, dir_rev});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic strobe(logic [3:0] d);
        shift_stb = 1'b1; din = d;
        tick();
        shift_stb = 1'b0;
    endtask

    task automatic latch_pulse();
        lat_clk = 1'b1; tick(); tick();
        lat_clk = 1'b0; tick();
    endtask

    function automatic logic [1:0] col_code(int c);
        return lvl_code[2*c+:2];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit pass_ok;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 outgoing enable", en_left_o, 1);
        check("R1 column 0 code", col_code(0), 1);
        check("R1 column 79 code", col_code(79), 1);

        // R2 nibble mode, left to right
        phase = "R2";
        for (int k = 0; k < 20; k++) strobe(4'((k * 5 + 3) & 15));
        check("R7 token after 20 nibbles", en_left_o, 0);
        check("R5 codes before latch", col_code(0), 1);
        phase = "R7";
        for (int k = 0; k < 3; k++) strobe(4'hF);
        phase = "R8";
        lat_clk = 1'b1; tick();
        check("R8 token restored", en_left_o, 1);
        tick(); lat_clk = 1'b0; tick();
        pass_ok = 1;
        for (int k = 0; k < 20; k++)
            for (int j = 0; j < 4; j++)
                if (col_code(4*k+j)[1] != (((k * 5 + 3) >> j) & 1)) pass_ok = 0;
        check("R2 nibble placement", pass_ok, 1);

        // R6 token withheld
        phase = "R6";
        load_sel = 1'b1; en_right_i = 1'b1;
        for (int k = 0; k < 85; k++) strobe(4'hF);
        check("R6 token not passed", en_left_o, 1);

        // R3 serial, left to right; upper bits of din junk
        phase = "R3";
        en_right_i = 1'b0;
        for (int k = 0; k < 80; k++) strobe({3'b101, 1'((k % 3) == 0)});
        check("R7 token after 80 bits", en_left_o, 0);
        latch_pulse();
        pass_ok = 1;
        for (int k = 0; k < 80; k++)
            if (col_code(k) != (((k % 3) == 0) ? 2'b11 : 2'b01)) pass_ok = 0;
        check("R3 serial placement", pass_ok, 1);

        // R4 reversed serial, token now from the left pin
        phase = "R4";
        dir_rev = 1'b1; en_right_i = 1'b1; en_left_i = 1'b0;
        tick();
        check("R9 right pin drives", en_right_oe, 1);
        for (int k = 0; k < 80; k++) strobe({3'b000, 1'((k % 5) < 2)});
        latch_pulse();
        pass_ok = 1;
        for (int k = 0; k < 80; k++)
            if (col_code(79 - k)[1] != ((k % 5) < 2)) pass_ok = 0;
        check("R4 reversed serial placement", pass_ok, 1);

        // R4 reversed nibble
        load_sel = 1'b0;
        for (int k = 0; k < 20; k++) strobe(4'((k * 7 + 9) & 15));
        latch_pulse();
        pass_ok = 1;
        for (int k = 0; k < 20; k++)
            for (int j = 0; j < 4; j++)
                if (col_code(79 - (4*k+j))[1] != (((k * 7 + 9) >> j) & 1)) pass_ok = 0;
        check("R4 reversed nibble placement", pass_ok, 1);

        // R8 strobes during latch-high are ignored and count restarts
        phase = "R8";
        load_sel = 1'b1;
        lat_clk = 1'b1;
        for (int k = 0; k < 5; k++) strobe(4'h1);
        lat_clk = 1'b0; tick();
        for (int k = 0; k < 79; k++) strobe(4'h0);
        check("R8 count restarted", en_left_o, 1);
        strobe(4'h0);
        check("R8 full after 80", en_left_o, 0);

        // R10 AC phase codes
        phase = "R10";
        ac_phase = 1'b1; tick();
        check("R10 latched one with ac high", col_code(79 - 3), 2'b00);
        ac_phase = 1'b0; tick();
        check("R10 latched one with ac low", col_code(79 - 3), 2'b11);

        // R11 blanking
        phase = "R11";
        blank_n = 1'b0; tick();
        check("R11 blank column 0", col_code(0), 0);
        check("R11 blank whole row", (lvl_code == '0), 1);
        blank_n = 1'b1; tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule